// File: doc/BRIEF.md
# TDM Frame Sync and Slot Sequencer

This block turns a stream of bit-clock enables into the framing of a time-division serial link. It counts bit periods into words and words into frames, drives the transmit and receive frame sync pins, and marks where each slot and each frame begins. A serial shifter next to it uses these strobes to load and unload data words. Clock division and data shifting live outside this block.

The 5-bit rate field is read one of two ways. In normal mode it gives the frame length in words minus one, and only the first word of each frame carries data. In network mode it gives the slot count minus one, and every word is a slot. Network mode with a rate field of zero is an on-demand mode. In that mode no periodic sync is made, and a frame is started only after a transmit-data write. Each sync pin can be word-long or bit-long. A word-long sync can start one bit early, and either polarity can be chosen.

All outputs are registered. They change only in the cycle after a clock edge on which `bit_en` was high, and they hold until the next such edge. The configuration inputs are assumed static while out of reset. `word_len` is assumed to be between 2 and 2^LEN_W-1.

Top module: `tdm_frame_seq`

## Requirements
- R1: While `rst_n` is low, and just after it is released, both sync pins sit at their inactive level (equal to `fs_active_low`), and `slot_start`, `tx_last_start` and `rx_last_end` are 0.
- R2: Each `bit_en` edge issues one bit. A word is `word_len` bits, and a frame is `rate_div`+1 words. In normal mode (`net_mode`=0), `slot_start` pulses only on the first bit of each frame, with `slot_idx`=0.
- R3: In periodic network mode (`net_mode`=1, `rate_div`≠0), `slot_start` pulses for one cycle on the first bit of every word. `slot_idx` counts 0 to `rate_div` and then wraps to 0.
- R4: A word-long sync with `fs_early`=0 is active for exactly the `word_len` bits of the first word of a frame.
- R5: A word-long sync with `fs_early`=1 starts one bit earlier. It covers the final bit of the preceding frame and the first `word_len`-1 bits of the new frame's first word.
- R6: A bit-long sync is active only for the first bit of a frame. `fs_early` does not move it.
- R7: `fs_len_code` sets the receive/transmit sync lengths as follows: 2'b00 word/word, 2'b01 word/bit, 2'b10 bit/bit, 2'b11 bit/word.
- R8: `fs_active_low`=0 drives an active sync high. `fs_active_low`=1 drives it low.
- R9: In normal mode with `rate_div`=0, both syncs are bit-long whatever `fs_len_code` holds.
- R10: In on-demand mode (`net_mode`=1, `rate_div`=0), no sync and no `slot_start` occur until `tx_wr` is seen. A write makes the next word boundary a frame start with a sync and `slot_start` (`slot_idx`=0). A write in the same cycle that such a frame is consumed is kept for the following word.
- R11: `tx_last_start` pulses together with the `slot_start` of slot `rate_div`. `rx_last_end` pulses after the edge that issues the final bit of that slot. Both pulse only in periodic network mode.
- R12: In network mode, `slot_fs_flag` is 1 during the slot in which a sync occurred and 0 in every other slot. In normal mode it is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle enable per bit period |
| word_len | input | LEN_W | Bits per word |
| rate_div | input | SLOT_W | Frame-rate field: ratio-1 (normal) or slots-1 (network) |
| net_mode | input | 1 | 0 normal, 1 network |
| fs_len_code | input | 2 | Receive/transmit sync length code |
| fs_early | input | 1 | Word-long sync starts one bit early |
| fs_active_low | input | 1 | Sync polarity |
| tx_wr | input | 1 | Transmit data written strobe |
| fs_tx_pin | output | 1 | Transmit frame sync pin value |
| fs_rx_pin | output | 1 | Receive frame sync pin value |
| slot_start | output | 1 | First bit of a data slot |
| slot_idx | output | SLOT_W | Index of current slot |
| tx_last_start | output | 1 | Final slot of the frame begins |
| rx_last_end | output | 1 | Final bit of the final slot issued |
| slot_fs_flag | output | 1 | Sync occurred in the current slot |

## Verification
In on-demand mode, a transmit write can land in the very cycle that a pending request is consumed at a word boundary. The pending state must then survive, and the next word must open a second frame. The bench holds `tx_wr` high across a long run of cycles, and it also raises `tx_wr` at random, so this coincidence occurs many times. A behavioural model decides for each word whether a frame starts, and every cycle it compares its result with `slot_start` and both sync pins. Early word syncs also overlap the final-bit strobe of the previous frame. Those cases are judged the same way, with `rx_last_end` and the pins compared in one cycle.

// File: rtl/tdm_seq_pkg.sv
// Package: shared sync-length encoding and decode helpers for the frame sequencer.
// Assumes the 2-bit code order rx/tx: 00 word/word, 01 word/bit, 10 bit/bit, 11 bit/word.
package tdm_seq_pkg;

    typedef enum logic [1:0] {
        FSL_WORD_WORD = 2'b00,
        FSL_WORD_BIT  = 2'b01,
        FSL_BIT_BIT   = 2'b10,
        FSL_BIT_WORD  = 2'b11
    } fs_len_e;

    // True when the transmit sync of this code spans a whole word.
    function automatic logic tx_is_word(input fs_len_e code);
        return (code == FSL_WORD_WORD) || (code == FSL_BIT_WORD);
    endfunction

    // True when the receive sync of this code spans a whole word.
    function automatic logic rx_is_word(input fs_len_e code);
        return (code == FSL_WORD_WORD) || (code == FSL_WORD_BIT);
    endfunction

endpackage

// File: rtl/tdm_pos_counter.sv
// Position counter: tracks the bit within the word and the word within the frame.
// Advances on each bit_en. Assumes word_len >= 2 and static configuration out of reset.
module tdm_pos_counter #(
    parameter int LEN_W  = 6,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [SLOT_W-1:0] last_slot,
    output logic [SLOT_W-1:0] slot_q,
    output logic              word_start,
    output logic              word_end,
    output logic              frame_end
);
    localparam logic [LEN_W-1:0] ONE_BIT = LEN_W'(1);

    logic [LEN_W-1:0] bit_q;
    logic [LEN_W-1:0] wl_m1;

    assign wl_m1      = word_len - ONE_BIT;
    assign word_start = (bit_q == '0);
    assign word_end   = (bit_q >= wl_m1);
    assign frame_end  = word_end && (slot_q >= last_slot);

    // Step the bit position and wrap words into slots and frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (bit_en) begin
            if (word_end) begin
                bit_q  <= '0;
                slot_q <= (slot_q >= last_slot) ? '0 : slot_q + SLOT_W'(1);
            end else begin
                bit_q <= bit_q + ONE_BIT;
            end
        end
    end

    a_r2_bit_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q < word_len);
    a_r3_slot_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= last_slot);
endmodule

// File: rtl/tdm_demand_tracker.sv
// On-demand tracker: holds a request raised by a transmit write until a word boundary
// consumes it. Records whether the current word is an on-demand frame.
// Assumes on_demand is static out of reset. A write that coincides with consumption is kept.
module tdm_demand_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic on_demand,
    input  logic word_start,
    input  logic tx_wr,
    output logic pend_q,
    output logic live_q
);
    logic consume;

    assign consume = bit_en && word_start;

    // Keep the request pending and latch frame liveness at each word start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            live_q <= 1'b0;
        end else begin
            pend_q <= on_demand && ((pend_q && !consume) || tx_wr);
            if (consume) live_q <= on_demand && pend_q;
        end
    end

    a_r10_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (on_demand && tx_wr) |=> pend_q);
endmodule

// File: rtl/tdm_sync_gen.sv
// Sync generator: registers the active level of the transmit and receive syncs for each
// bit being issued. Word-long or bit-long per direction, with an optional one-bit advance.
// Assumes the position inputs describe the bit issued at this bit_en edge.
module tdm_sync_gen
    import tdm_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       word_start,
    input  logic       word_end,
    input  logic       frame_end,
    input  logic       first_live,
    input  logic       next_live,
    input  logic       force_bit,
    input  logic [1:0] len_code,
    input  logic       early,
    output logic       tx_act_q,
    output logic       rx_act_q
);
    logic word_sync;
    logic bit_sync;
    logic tx_word;
    logic rx_word;

    // Choose the sync shape for the bit being issued.
    always_comb begin
        if (early) word_sync = (first_live && !word_end) || (frame_end && next_live);
        else       word_sync = first_live;
        bit_sync = first_live && word_start;
        tx_word  = !force_bit && tx_is_word(fs_len_e'(len_code));
        rx_word  = !force_bit && rx_is_word(fs_len_e'(len_code));
    end

    // Register both sync levels once per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_act_q <= 1'b0;
            rx_act_q <= 1'b0;
        end else if (bit_en) begin
            tx_act_q <= tx_word ? word_sync : bit_sync;
            rx_act_q <= rx_word ? word_sync : bit_sync;
        end
    end

    a_r2_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_en)) |-> $stable(tx_act_q));
    a_r2_rx_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_en)) |-> $stable(rx_act_q));
endmodule

// File: rtl/tdm_frame_seq.sv
// Top: frame sync and slot sequencer for normal, network and on-demand TDM framing.
// Outputs are registered and change only after a bit_en edge. Assumes word_len >= 2
// and static configuration while out of reset.
module tdm_frame_seq #(
    parameter int LEN_W  = 6,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [SLOT_W-1:0] rate_div,
    input  logic              net_mode,
    input  logic [1:0]        fs_len_code,
    input  logic              fs_early,
    input  logic              fs_active_low,
    input  logic              tx_wr,
    output logic              fs_tx_pin,
    output logic              fs_rx_pin,
    output logic              slot_start,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              tx_last_start,
    output logic              rx_last_end,
    output logic              slot_fs_flag
);
    logic [SLOT_W-1:0] slot_q;
    logic word_start, word_end, frame_end;
    logic pend_q, live_q;
    logic tx_act_q, rx_act_q;
    logic on_demand, periodic_net, force_bit;
    logic first_live, next_live, start_now;
    logic start_q, tx_last_q, rx_last_q, flag_q;
    logic [SLOT_W-1:0] idx_q;

    tdm_pos_counter #(.LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_len(word_len),
        .last_slot(rate_div), .slot_q(slot_q), .word_start(word_start),
        .word_end(word_end), .frame_end(frame_end)
    );

    tdm_demand_tracker u_dem (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .on_demand(on_demand),
        .word_start(word_start), .tx_wr(tx_wr), .pend_q(pend_q), .live_q(live_q)
    );

    tdm_sync_gen u_sync (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_start(word_start),
        .word_end(word_end), .frame_end(frame_end), .first_live(first_live),
        .next_live(next_live), .force_bit(force_bit), .len_code(fs_len_code),
        .early(fs_early), .tx_act_q(tx_act_q), .rx_act_q(rx_act_q)
    );

    // Decode the mode and decide whether the current word opens a live frame.
    always_comb begin
        on_demand    = net_mode && (rate_div == '0);
        periodic_net = net_mode && !on_demand;
        force_bit    = !net_mode && (rate_div == '0);
        if (on_demand) first_live = (slot_q == '0) && (word_start ? pend_q : live_q);
        else           first_live = (slot_q == '0);
        next_live    = on_demand ? pend_q : 1'b1;
        start_now    = bit_en && word_start && (periodic_net || first_live);
    end

    // Register slot strobes, slot index and the per-slot sync flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            tx_last_q <= 1'b0;
            rx_last_q <= 1'b0;
            idx_q     <= '0;
            flag_q    <= 1'b0;
        end else begin
            start_q   <= start_now;
            tx_last_q <= bit_en && word_start && periodic_net && (slot_q == rate_div);
            rx_last_q <= bit_en && frame_end && periodic_net;
            if (start_now) idx_q <= slot_q;
            if (bit_en && word_start) flag_q <= first_live;
        end
    end

    assign fs_tx_pin     = tx_act_q ^ fs_active_low;
    assign fs_rx_pin     = rx_act_q ^ fs_active_low;
    assign slot_start    = start_q;
    assign slot_idx      = idx_q;
    assign tx_last_start = tx_last_q;
    assign rx_last_end   = rx_last_q;
    assign slot_fs_flag  = net_mode ? flag_q : 1'b1;

    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> !slot_start);
    a_r11_tx_last_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last_start |-> (slot_start && slot_idx == rate_div));
    a_r11_rx_last_net_only: assert property (@(posedge clk) disable iff (!rst_n)
        rx_last_end |-> (net_mode && rate_div != '0));
    a_r12_flag_other_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && slot_idx != '0) |-> !slot_fs_flag);
endmodule

// File: tb/tdm_frame_seq_tb.sv
module tdm_frame_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W  = 6;
    localparam int SLOT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic [LEN_W-1:0]  word_len = 6'd4;
    logic [SLOT_W-1:0] rate_div = 5'd1;
    logic net_mode = 1'b0;
    logic [1:0] fs_len_code = 2'b00;
    logic fs_early = 1'b0;
    logic fs_active_low = 1'b0;
    logic tx_wr = 1'b0;
    logic fs_tx_pin, fs_rx_pin, slot_start, tx_last_start, rx_last_end, slot_fs_flag;
    logic [SLOT_W-1:0] slot_idx;

    int tests = 0;
    int fails = 0;
    bit armed = 0;
    bit done = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_frame_seq #(.LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_len(word_len),
        .rate_div(rate_div), .net_mode(net_mode), .fs_len_code(fs_len_code),
        .fs_early(fs_early), .fs_active_low(fs_active_low), .tx_wr(tx_wr),
        .fs_tx_pin(fs_tx_pin), .fs_rx_pin(fs_rx_pin), .slot_start(slot_start),
        .slot_idx(slot_idx), .tx_last_start(tx_last_start), .rx_last_end(rx_last_end),
        .slot_fs_flag(slot_fs_flag)
    );

    // Behavioural reference state
    int m_b = 0, m_s = 0;
    bit m_pend = 0, m_live = 0;
    bit e_txa = 0, e_rxa = 0, e_ss = 0, e_txl = 0, e_rxl = 0, e_flag = 0;
    int e_idx = 0;

    always @(posedge clk) begin
        armed <= 1'b1;
        if (!rst_n) begin
            m_b = 0; m_s = 0; m_pend = 0; m_live = 0;
            e_txa = 0; e_rxa = 0; e_ss = 0; e_txl = 0; e_rxl = 0; e_flag = 0; e_idx = 0;
        end else begin
            int  wl, ns;
            bit  od, pn, frc, ws, we, fe, first, nxt, wsync, bsync, txw, rxw, cons;
            wl  = int'(word_len);
            ns  = int'(rate_div);
            od  = net_mode && ns == 0;
            pn  = net_mode && ns != 0;
            frc = !net_mode && ns == 0;
            ws  = (m_b == 0);
            we  = (m_b == wl - 1);
            fe  = we && (m_s == ns);
            first = (m_s == 0) && (od ? (ws ? m_pend : m_live) : 1'b1);
            nxt   = od ? m_pend : 1'b1;
            cons  = 0;
            e_ss = 0; e_txl = 0; e_rxl = 0;
            if (bit_en) begin
                wsync = fs_early ? ((first && !we) || (fe && nxt)) : first;
                bsync = first && ws;
                txw = !frc && (fs_len_code == 2'b00 || fs_len_code == 2'b11);
                rxw = !frc && (fs_len_code == 2'b00 || fs_len_code == 2'b01);
                e_txa = txw ? wsync : bsync;
                e_rxa = rxw ? wsync : bsync;
                if (ws && (pn || first)) begin e_ss = 1; e_idx = m_s; end
                e_txl = ws && pn && (m_s == ns);
                e_rxl = fe && pn;
                if (ws) begin e_flag = first; m_live = od && m_pend; cons = 1; end
                if (we) begin m_b = 0; m_s = (m_s >= ns) ? 0 : m_s + 1; end
                else m_b = m_b + 1;
            end
            m_pend = od && ((m_pend && !cons) || tx_wr);
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // Compare every output with the reference on each falling edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            string sreq;
            sreq = (net_mode && rate_div == 0) ? "R10" : (net_mode ? "R3" : "R2");
            check(cur_req, "fs_tx_pin", fs_tx_pin, e_txa ^ fs_active_low);
            check(cur_req, "fs_rx_pin", fs_rx_pin, e_rxa ^ fs_active_low);
            check(sreq, "slot_start", slot_start, e_ss);
            if (e_ss) check(sreq, "slot_idx", int'(slot_idx), e_idx);
            check("R11", "tx_last_start", tx_last_start, e_txl);
            check("R11", "rx_last_end", rx_last_end, e_rxl);
            check("R12", "slot_fs_flag", slot_fs_flag, net_mode ? e_flag : 1'b1);
        end
    end

    task automatic run_phase(input string req, input bit net, input int rate, input int wl,
                             input int code, input bit early, input bit inv,
                             input int density, input bit dem);
        @(negedge clk);
        rst_n = 0; bit_en = 0; tx_wr = 0;
        net_mode = net; rate_div = SLOT_W'(rate); word_len = LEN_W'(wl);
        fs_len_code = 2'(code); fs_early = early; fs_active_low = inv;
        repeat (2) @(negedge clk);
        check("R1", "reset fs_tx_pin", fs_tx_pin, inv);
        check("R1", "reset fs_rx_pin", fs_rx_pin, inv);
        check("R1", "reset strobes", {slot_start, tx_last_start, rx_last_end}, 0);
        cur_req = req;
        rst_n = 1;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            bit_en = (density <= 1) ? 1'b1 : (($urandom % density) == 0);
            tx_wr  = dem && ((($urandom % 23) == 0) || (i >= 300 && i < 340));
        end
    endtask

    initial begin
        run_phase("R4", 1'b0, 2, 4, 0, 1'b0, 1'b0, 1, 1'b0);
        run_phase("R6", 1'b0, 3, 5, 2, 1'b1, 1'b0, 2, 1'b0);
        run_phase("R5", 1'b1, 5, 6, 0, 1'b1, 1'b0, 1, 1'b0);
        run_phase("R7", 1'b1, 3, 3, 1, 1'b0, 1'b1, 2, 1'b0);
        run_phase("R7", 1'b1, 31, 2, 3, 1'b1, 1'b0, 3, 1'b0);
        run_phase("R9", 1'b0, 0, 4, 0, 1'b1, 1'b0, 1, 1'b0);
        run_phase("R10", 1'b1, 0, 5, 0, 1'b1, 1'b0, 2, 1'b1);
        run_phase("R8", 1'b1, 1, 8, 0, 1'b0, 1'b1, 1, 1'b0);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL R1 watchdog expired got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule